// File: doc/BRIEF.md
# Cascadable Synchronous Preset Counter

The block is a binary up-counter built from 4-bit slices. A parameter sets the number of slices, and the slices are chained inside the block into one wide counter. Every flip-flop changes on the same rising clock edge, so the outputs move together and show no ripple glitches.

On each edge the counter does one of four things, in a fixed priority. It clears to zero, or it loads a parallel word, or it advances by one, or it holds. Clear and load are both synchronous and active low. Counting needs two enables. The first enable, `cnt_en`, goes to every slice. The second enable, `chain_en`, goes only to the lowest slice. Each slice passes its carry to the next slice as that slice's second enable. Only the second enable reaches the carry output, and it reaches it without passing through a register.

A shorter count cycle is made outside the block. Decode the chosen last value and drive `clr_n` low while that value is present. The counter then returns to zero on the next edge.

Top module: `cascade_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes all zeros after that edge. This holds whatever the levels of `load_n`, `cnt_en` and `chain_en`.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` becomes `din` after that edge, and the enables have no effect. Bit i of `din` goes to bit i of `q`, and bit 0 is the least significant bit.
- R3: When `clr_n`, `load_n`, `cnt_en` and `chain_en` are all high at a rising edge, `q` becomes `q`+1 modulo 2^W.
- R4: When `clr_n` and `load_n` are high and either `cnt_en` or `chain_en` is low at a rising edge, `q` keeps its value.
- R5: `rco` is high exactly when `chain_en` is high and every bit of `q` is one. A change on `chain_en` reaches `rco` without a clock edge.
- R6: A slice above the lowest one advances only on an edge where every slice below it holds all ones. So 0x0F counts to 0x10, and 0xFF counts to 0x00.
- R7: Reference sequence (two slices): clear, preset to 0xFC, then count through FC, FD, FE, FF, 00, 01, 02, then hold while an enable is low. `rco` is high only during state FF.
- R8: If `clr_n` is driven low whenever `q` equals a chosen value M, the counter repeats the cycle 0 .. M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all slices |
| chain_en | input | 1 | Count enable for the lowest slice; also gates `rco` |
| din | input | W = 4*NUM_STAGES | Parallel load data, bit 0 is the least significant bit |
| q | output | W | Counter value |
| rco | output | 1 | High when `chain_en` is high and `q` is all ones |

## Verification
The bench drives clear and load low on the same edge. A design with the priority reversed would show the data word instead of zero.

It loads while both enables are high. A counter that lets the enables act during a load would show data+1.

It checks the carry path at values where only the lowest slice is full (0x0F) and at the full-chain maximum (0xFF). This catches an upper slice that advances too early, or a carry that ignores the higher slices.

It toggles `chain_en` between clock edges at the maximum value. A carry sent through a register, or one that ignores `chain_en`, would show the wrong level on `rco`.

It runs a truncated cycle through external feedback on `clr_n`, and a full wrap from 0xFF to 0x00.

// File: rtl/cnt_pkg.sv
// Shared definitions for the cascadable counter.
// Assumes slices of a fixed 4-bit width.
package cnt_pkg;
    localparam int SLICE_W = 4;

    // Action taken on a clock edge, listed from highest to lowest priority.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd3,
        ACT_LOAD  = 2'd2,
        ACT_COUNT = 2'd1,
        ACT_HOLD  = 2'd0
    } act_t;
endpackage

// File: rtl/cnt_ctrl.sv
// Edge-action decoder.
// Turns the clear, load and enable levels into a single action.
// The priority is clear, then load, then count, then hold.
// Assumes all inputs are synchronous to the clock that uses the result.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_a,
    input  logic en_b,
    output act_t act
);
    // Purpose: pick the highest-priority action that is requested.
    always_comb begin
        if (!clr_n)
            act = ACT_CLEAR;
        else if (!load_n)
            act = ACT_LOAD;
        else if (en_a && en_b)
            act = ACT_COUNT;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/cnt_stage.sv
// One counter slice.
// Holds a register of width SW, applies the decoded edge action, and
// drives a carry that is high when the second enable is high and the
// slice is all ones.
// Assumes the second enable comes from the slice below, or from the
// block input for the lowest slice.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q,
    output logic          carry
);
    act_t          act;
    logic [SW-1:0] q_r;

    cnt_ctrl u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_a   (en_a),
        .en_b   (en_b),
        .act    (act)
    );

    // Purpose: update the slice register on the rising edge.
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: q_r <= '0;
            ACT_LOAD:  q_r <= d;
            ACT_COUNT: q_r <= q_r + 1'b1;
            default:   q_r <= q_r;
        endcase
    end

    // Purpose: the carry follows en_b with no register in the path.
    assign carry = en_b & (&q_r);
    assign q     = q_r;
endmodule

// File: rtl/cascade_counter.sv
// Top level: NUM_STAGES slices chained into one W-bit counter.
// cnt_en goes to every slice. chain_en goes only to the lowest slice.
// Each slice's carry becomes the second enable of the slice above it,
// and the carry of the highest slice drives rco.
// Assumes all inputs are synchronous to clk.
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int NUM_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic                          cnt_en,
    input  logic                          chain_en,
    input  logic [NUM_STAGES*SLICE_W-1:0] din,
    output logic [NUM_STAGES*SLICE_W-1:0] q,
    output logic                          rco
);
    localparam int W = NUM_STAGES * SLICE_W;

    logic [NUM_STAGES-1:0] carry;
    logic [NUM_STAGES-1:0] t_chain;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        // Purpose: pick the second enable for slice k.
        if (k == 0) begin : g_first
            assign t_chain[k] = chain_en;
        end else begin : g_next
            assign t_chain[k] = carry[k-1];
        end

        cnt_stage #(.SW(SLICE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_a   (cnt_en),
            .en_b   (t_chain[k]),
            .d      (din[k*SLICE_W +: SLICE_W]),
            .q      (q[k*SLICE_W +: SLICE_W]),
            .carry  (carry[k])
        );
    end

    assign rco = carry[NUM_STAGES-1];

    // Purpose: the derived width must match the port width.
    initial begin
        if (W != $bits(q)) $display("cascade_counter: width mismatch");
    end
endmodule

// File: rtl/cascade_counter_chk.sv
// Assertion checker, attached to cascade_counter with bind.
// armed becomes 1 after the first clock edge, so no property looks at
// values from before that edge.
module cascade_counter_chk #(
    parameter int NUM_STAGES = 2
) (
    input logic                    clk,
    input logic                    clr_n,
    input logic                    load_n,
    input logic                    cnt_en,
    input logic                    chain_en,
    input logic [NUM_STAGES*4-1:0] din,
    input logic [NUM_STAGES*4-1:0] q,
    input logic                    rco
);
    logic armed = 1'b0;

    // Purpose: mark that at least one edge has passed.
    always_ff @(posedge clk) armed <= 1'b1;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> (q == $past(din)));

    assert_count_R3: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (load_n && cnt_en && chain_en) |=> (q == $past(q) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(q));

    assert_carry_R5: assert property (@(posedge clk) disable iff (!armed)
        rco == (chain_en && (&q)));
endmodule

bind cascade_counter cascade_counter_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .din      (din),
    .q        (q),
    .rco      (rco)
);

// File: tb/cascade_counter_tb.sv
`timescale 1ns/1ps
module cascade_counter_tb;
    localparam int NS = 2;
    localparam int W  = NS * 4;

    logic         clk = 1'b0;
    logic         clr_n, load_n, cnt_en, chain_en;
    logic [W-1:0] din;
    logic [W-1:0] q;
    logic         rco;
    int           checks = 0;
    int           errors = 0;

    cascade_counter #(.NUM_STAGES(NS)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .q(q), .rco(rco)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
        clr_n = c; load_n = l; cnt_en = p; chain_en = t; din = d;
    endtask

    task automatic t_clear_first();
        drive(0, 0, 1, 1, 8'hAA);
        tick();
        chk("R1 clear beats load", q, '0);
        chk("R5 no carry at zero", {7'd0, rco}, '0);
    endtask

    task automatic t_load();
        drive(1, 0, 1, 1, 8'h5A);
        tick();
        chk("R2 load ignores enables", q, 8'h5A);
        drive(1, 0, 0, 0, 8'hC3);
        tick();
        chk("R2 load bit order", q, 8'hC3);
    endtask

    task automatic t_hold();
        drive(1, 1, 0, 1, '0);
        tick();
        chk("R4 hold cnt_en low", q, 8'hC3);
        drive(1, 1, 1, 0, '0);
        tick();
        chk("R4 hold chain_en low", q, 8'hC3);
        drive(1, 1, 1, 1, '0);
        tick();
        chk("R3 count one", q, 8'hC4);
    endtask

    task automatic t_ref_seq();
        logic [W-1:0] exp;
        drive(0, 1, 1, 1, '0);
        tick();
        chk("R7 clear", q, '0);
        drive(1, 0, 0, 0, 8'hFC);
        tick();
        chk("R7 preset", q, 8'hFC);
        exp = 8'hFC;
        drive(1, 1, 1, 1, '0);
        #1;
        chk("R7 rco low at FC", {7'd0, rco}, '0);
        for (int i = 0; i < 6; i++) begin
            tick();
            exp = exp + 1'b1;
            chk("R7 sequence", q, exp);
            chk("R7 rco only at FF", {7'd0, rco}, {7'd0, exp == 8'hFF});
        end
        drive(1, 1, 0, 1, '0);
        tick();
        tick();
        chk("R7 inhibit hold", q, 8'h02);
    endtask

    task automatic t_cascade();
        drive(1, 0, 0, 1, 8'h0F);
        tick();
        chk("R6 low slice full no carry", {7'd0, rco}, '0);
        drive(1, 1, 1, 1, '0);
        tick();
        chk("R6 0F to 10", q, 8'h10);
        drive(1, 0, 0, 1, 8'hFF);
        tick();
        chk("R5 rco high at max", {7'd0, rco}, 8'd1);
        chain_en = 0;
        #2;
        chk("R5 rco follows chain_en low", {7'd0, rco}, '0);
        chain_en = 1;
        #2;
        chk("R5 rco follows chain_en high", {7'd0, rco}, 8'd1);
        cnt_en = 1; load_n = 1;
        tick();
        chk("R6 wrap FF to 00", q, 8'h00);
    endtask

    task automatic t_truncate();
        logic [W-1:0] exp;
        drive(0, 1, 1, 1, '0);
        tick();
        exp = '0;
        for (int i = 0; i < 14; i++) begin
            clr_n = (q != 8'd9);
            tick();
            exp = (exp == 8'd9) ? '0 : exp + 1'b1;
            chk("R8 truncated cycle", q, exp);
        end
    endtask

    initial begin
        drive(0, 1, 0, 0, '0);
        #2;
        t_clear_first();
        t_load();
        t_hold();
        t_ref_seq();
        t_cascade();
        t_truncate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule